// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends words over a single serial line in non-return-to-zero form. Each frame is a low start bit, then eight or nine data bits sent least significant bit first, then a high stop bit. Between frames the line rests high. A host writes a word into a one-word holding buffer. A separate shift stage takes that word only when it is idle, or when the stop bit of the frame it is sending has finished. Because of this, a host that refills the buffer before the stop bit ends gets frames sent back to back with no idle time between them.

All bit timing comes from an external one-cycle enable pulse, `bit_tick`. A transfer into the shift stage happens only on a tick cycle, and every line bit lasts from one tick to the next. The ninth data bit is a separate host input. Software can use it to carry parity that it computes itself.

The block has two status outputs. `hold_empty` shows that the holding buffer can take a new word, and it can raise an interrupt through `irq_en`. `shift_empty` shows that no frame is in progress and has no interrupt attached. Pulling `tx_en` low aborts any frame in progress, but the buffered word is kept.

Top module: `ntx_serial_tx`

## Requirements
- R1: A frame is one low start bit, the data bits least significant first, and one high stop bit. `line_out` is high whenever no frame is in progress.
- R2: With `nine_bits`=1 a frame carries 9 data bits, and `wr_ext` is sent last as bit 8. With `nine_bits`=0 a frame carries 8 data bits and `wr_ext` has no effect on the line.
- R3: A transfer into the shift stage, and every change of `line_out` while `tx_en` stays high, happens only at a clock edge where `bit_tick` is 1. Each bit therefore lasts exactly one tick period.
- R4: The shift stage loads a buffered word only when it is idle or at the tick that ends the stop bit. In the second case the next start bit follows the stop bit with no idle gap.
- R5: When a word moves into the shift stage, the buffer empties and `hold_empty` rises two cycles after that tick edge, whatever the value of `irq_en`. Only a host write clears `hold_empty`.
- R6: From the second cycle after a host write (`wr_en`=1 at an edge), `hold_empty` reads 0. Its value in the first cycle after the write is not specified.
- R7: `irq` is high exactly when `hold_empty` and `irq_en` are both high.
- R8: `shift_empty` is 1 exactly when no frame is in progress.
- R9: A host write while the buffer is full replaces the pending word, and the earlier word is never sent. If a write and a transfer happen at the same edge, the shift stage takes the old word and the new word stays buffered.
- R10: While `tx_en` is 0, `line_out` is 1 and the shift stage is held idle. The buffered word is kept and is sent once `tx_en` returns to 1.
- R11: After reset, `line_out`, `hold_empty` and `shift_empty` are all 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable; low aborts the frame and forces the line high |
| bit_tick | input | 1 | One-cycle bit-rate enable pulse |
| nine_bits | input | 1 | 1: nine data bits per frame, 0: eight |
| wr_en | input | 1 | Host write strobe into the holding buffer |
| wr_data | input | DATA_W | Host data, low bits of the word |
| wr_ext | input | 1 | Ninth data bit for nine-bit frames |
| irq_en | input | 1 | Interrupt enable for the buffer-empty flag |
| line_out | output | 1 | Serial line, idles high |
| hold_empty | output | 1 | Holding buffer can accept a word |
| shift_empty | output | 1 | No frame in progress |
| irq | output | 1 | Buffer-empty interrupt request |

## Verification
The hardest case to reach is a host write that lands inside the narrow window of a frame in progress. This includes a write during the stop bit, a write at the same edge as a transfer, and a second write that overwrites a word still pending. The stimulus waits for `shift_empty` to fall and then writes while the frame is under way. Random write gaps, measured in clock cycles and not in ticks, move the writes across every position relative to the tick pulse, including the transfer edge itself. A separate directed case drops `tx_en` in the middle of a frame while a word is pending, to show that the word survives the abort and is sent afterwards.

// File: rtl/ntx_pkg.sv
package ntx_pkg;

  typedef enum logic [0:0] {
    SH_IDLE = 1'b0,
    SH_SEND = 1'b1
  } sh_state_e;

  // Line bits in one frame: start + data + optional ninth bit + stop
  function automatic int unsigned frame_len(input int unsigned dw, input logic nine);
    frame_len = dw + 2 + (nine ? 1 : 0);
  endfunction

endpackage

// File: rtl/ntx_holdbuf.sv
module ntx_holdbuf #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_ext,
  input  logic              take,
  output logic [DATA_W-1:0] word_q,
  output logic              ext_q,
  output logic              full_q
);

  logic [DATA_W-1:0] word_d;
  logic              ext_d;
  logic              full_d;

  // A host write wins over a same-edge transfer: the shifter samples
  // word_q (old word) while the new one lands here.
  always_comb begin
    word_d = word_q;
    ext_d  = ext_q;
    full_d = full_q;
    if (wr_en) begin
      word_d = wr_data;
      ext_d  = wr_ext;
      full_d = 1'b1;
    end else if (take) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      ext_q  <= 1'b0;
      full_q <= 1'b0;
    end else begin
      word_q <= word_d;
      ext_q  <= ext_d;
      full_q <= full_d;
    end
  end

endmodule

// File: rtl/ntx_shifter.sv
module ntx_shifter
  import ntx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              bit_tick,
  input  logic              nine_bits,
  input  logic              buf_full,
  input  logic [DATA_W-1:0] buf_data,
  input  logic              buf_ext,
  output logic              take,
  output logic              line,
  output logic              idle
);

  localparam int unsigned FRAME_W = DATA_W + 3;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

  sh_state_e          state_q, state_d;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic [CNT_W-1:0]   left_q,  left_d;
  logic               last_bit;

  assign last_bit = (state_q == SH_SEND) && (left_q == CNT_W'(1));
  assign take     = tx_en && bit_tick && buf_full &&
                    ((state_q == SH_IDLE) || last_bit);

  always_comb begin
    state_d = state_q;
    frame_d = frame_q;
    left_d  = left_q;
    if (!tx_en) begin
      state_d = SH_IDLE;
      frame_d = '1;
      left_d  = '0;
    end else if (take) begin
      state_d = SH_SEND;
      if (nine_bits) begin
        frame_d = {1'b1, buf_ext, buf_data, 1'b0};
      end else begin
        frame_d = {1'b1, 1'b1, buf_data, 1'b0};
      end
      left_d = CNT_W'(frame_len(DATA_W, nine_bits));
    end else if (bit_tick && (state_q == SH_SEND)) begin
      if (last_bit) begin
        state_d = SH_IDLE;
        frame_d = '1;
        left_d  = '0;
      end else begin
        frame_d = {1'b1, frame_q[FRAME_W-1:1]};
        left_d  = left_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SH_IDLE;
      frame_q <= '1;
      left_q  <= '0;
    end else begin
      state_q <= state_d;
      frame_q <= frame_d;
      left_q  <= left_d;
    end
  end

  assign line = (tx_en && (state_q == SH_SEND)) ? frame_q[0] : 1'b1;
  assign idle = (state_q == SH_IDLE);

endmodule

// File: rtl/ntx_flags.sv
module ntx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic buf_full,
  input  logic irq_en,
  output logic hold_empty,
  output logic irq
);

  logic empty_q, empty_d;

  // One register stage: the flag settles from the second cycle after a write
  always_comb begin
    empty_d = !buf_full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
    end else begin
      empty_q <= empty_d;
    end
  end

  assign hold_empty = empty_q;
  assign irq        = empty_q && irq_en;

endmodule

// File: rtl/ntx_serial_tx.sv
module ntx_serial_tx #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              bit_tick,
  input  logic              nine_bits,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_ext,
  input  logic              irq_en,
  output logic              line_out,
  output logic              hold_empty,
  output logic              shift_empty,
  output logic              irq
);

  logic [DATA_W-1:0] hb_word;
  logic              hb_ext;
  logic              hb_full;
  logic              sh_take;

  ntx_holdbuf #(.DATA_W(DATA_W)) i_holdbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .wr_ext  (wr_ext),
    .take    (sh_take),
    .word_q  (hb_word),
    .ext_q   (hb_ext),
    .full_q  (hb_full)
  );

  ntx_shifter #(.DATA_W(DATA_W)) i_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .bit_tick  (bit_tick),
    .nine_bits (nine_bits),
    .buf_full  (hb_full),
    .buf_data  (hb_word),
    .buf_ext   (hb_ext),
    .take      (sh_take),
    .line      (line_out),
    .idle      (shift_empty)
  );

  ntx_flags i_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .buf_full   (hb_full),
    .irq_en     (irq_en),
    .hold_empty (hold_empty),
    .irq        (irq)
  );

endmodule

// File: rtl/ntx_serial_tx_chk.sv
module ntx_serial_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic bit_tick,
  input logic wr_en,
  input logic irq_en,
  input logic line_out,
  input logic hold_empty,
  input logic shift_empty,
  input logic irq
);

  // R1: line rests high outside a frame
  p_idle_mark_r1: assert property (@(posedge clk) disable iff (!rst_n)
    shift_empty |-> line_out);

  // R1: a frame opens with a low start bit
  p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shift_empty) |-> !line_out);

  // R3: frames begin only after a tick edge
  p_load_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shift_empty) |-> $past(bit_tick));

  // R3: no line change without a tick while enabled
  p_hold_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && $past(tx_en) && !$past(bit_tick)) |-> $stable(line_out));

  // R5: flag rises only as a result of a tick-edge transfer
  p_set_on_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_empty) |-> $past(bit_tick, 2));

  // R6: flag reads cleared from the second cycle after a write
  p_clear_after_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en, 2) |-> !hold_empty);

  // R7: interrupt needs both the flag and the enable
  p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && hold_empty));

  // R10: disable holds the line high and idles the shifter
  p_dis_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> line_out);

  p_dis_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> shift_empty);

endmodule

bind ntx_serial_tx ntx_serial_tx_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tx_en       (tx_en),
  .bit_tick    (bit_tick),
  .wr_en       (wr_en),
  .irq_en      (irq_en),
  .line_out    (line_out),
  .hold_empty  (hold_empty),
  .shift_empty (shift_empty),
  .irq         (irq)
);

// File: tb/test_ntx_serial_tx.sv
`timescale 1ns/1ps
module test_ntx_serial_tx;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tx_en;
  logic       bit_tick;
  logic       nine_bits;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       wr_ext;
  logic       irq_en;
  logic       line_out, hold_empty, shift_empty, irq;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  ntx_serial_tx #(.DATA_W(8)) i_ntx_serial_tx (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .bit_tick(bit_tick),
    .nine_bits(nine_bits), .wr_en(wr_en), .wr_data(wr_data), .wr_ext(wr_ext),
    .irq_en(irq_en), .line_out(line_out), .hold_empty(hold_empty),
    .shift_empty(shift_empty), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Tick generator: one pulse every tick_div cycles
  int tick_div = 4;
  int tick_cnt = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      bit_tick = 1'b0;
      tick_cnt = 0;
    end else begin
      tick_cnt++;
      if (tick_cnt >= tick_div) begin
        bit_tick = 1'b1;
        tick_cnt = 0;
      end else begin
        bit_tick = 1'b0;
      end
    end
  end

  // Requirement model: buffer, frame progress, expected word queue
  int  exp_q[$];
  bit  m_valid, m_busy, m_ext, m_he, m_wr_edge, m_take;
  int  m_left;
  int  m_word;
  int  dec_state = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0; m_busy = 0; m_left = 0; m_he = 1; m_wr_edge = 0;
      exp_q.delete();
    end else begin
      m_he      = !m_valid;
      m_wr_edge = wr_en;
      m_take    = tx_en && bit_tick && m_valid && (!m_busy || m_left == 1);
      if (!tx_en) begin
        if (m_busy && dec_state != 0) void'(exp_q.pop_front());
        m_busy = 0; m_left = 0;
      end else if (m_take) begin
        exp_q.push_back(nine_bits ? ((int'(m_ext) << 8) | m_word) : m_word);
        m_busy = 1;
        m_left = nine_bits ? 11 : 10;
      end else if (bit_tick && m_busy) begin
        if (m_left == 1) m_busy = 0;
        else m_left--;
      end
      if (wr_en) begin
        m_valid = 1; m_word = int'(wr_data); m_ext = wr_ext;
      end else if (m_take) begin
        m_valid = 0;
      end
    end
  end

  // Line decoder and per-cycle port checks, sampled 2 ns after the edge
  int dec_n, dec_val, dec_bits, idle_ticks, last_gap, last_rx, rx_count;
  bit prev_line = 1, prev_en = 0;

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk(shift_empty == !m_busy, "R8 shift_empty", shift_empty, !m_busy);
      if (!m_busy) chk(line_out == 1'b1, "R1 idle line", line_out, 1);
      if (!m_wr_edge) chk(hold_empty == m_he, "R5 hold_empty", hold_empty, m_he);
      chk(irq == (hold_empty && irq_en), "R7 irq", irq, hold_empty && irq_en);
      if (!bit_tick && tx_en && prev_en)
        chk(line_out == prev_line, "R3 bit held between ticks", line_out, prev_line);
      if (!tx_en) begin
        dec_state = 0; idle_ticks = 0;
      end else if (bit_tick) begin
        case (dec_state)
          0: if (!line_out) begin
               last_gap = idle_ticks; idle_ticks = 0;
               dec_state = 1; dec_n = 0; dec_val = 0;
               dec_bits = nine_bits ? 9 : 8;
             end else idle_ticks++;
          1: begin
               dec_val |= int'(line_out) << dec_n;
               dec_n++;
               if (dec_n == dec_bits) dec_state = 2;
             end
          default: begin
               chk(line_out == 1'b1, "R1 stop bit", line_out, 1);
               if (exp_q.size() == 0) begin
                 chk(0, "R4 unexpected frame", dec_val, -1);
               end else begin
                 int e;
                 e = exp_q.pop_front();
                 chk(dec_val == e, dec_bits == 9 ? "R2 nine-bit frame" : "R1 frame data",
                     dec_val, e);
               end
               last_rx = dec_val; rx_count++;
               dec_state = 0;
             end
        endcase
      end
      prev_line = line_out;
      prev_en   = tx_en;
    end
  end

  task automatic host_write(input logic [7:0] d, input logic e);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; wr_ext = e;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_busy || m_valid || dec_state != 0) @(posedge clk);
    repeat (2 * tick_div + 4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_frame_start();
    @(posedge clk); #2;
    while (shift_empty) begin @(posedge clk); #2; end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    int cnt0;
    seed = $urandom(32'h5A17);
    rst_n = 0; tx_en = 1; nine_bits = 0; wr_en = 0; wr_data = 0; wr_ext = 0; irq_en = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #2;
    chk(line_out == 1, "R11 reset line", line_out, 1);
    chk(hold_empty == 1, "R11 reset hold_empty", hold_empty, 1);
    chk(shift_empty == 1, "R11 reset shift_empty", shift_empty, 1);
    chk(irq == 0, "R7 irq masked after reset", irq, 0);

    // R6: flag cleared from the second cycle after a write
    host_write(8'hA5, 1'b0);
    @(posedge clk); #2;
    chk(hold_empty == 0, "R6 cleared after write", hold_empty, 0);
    wait_idle();
    chk(last_rx == 'hA5, "R1 LSB-first frame", last_rx, 'hA5);
    chk(hold_empty == 1 && irq == 0, "R5 set with irq disabled", hold_empty, 1);
    irq_en = 1;
    @(posedge clk); #2;
    chk(irq == 1, "R7 irq enabled", irq, 1);

    // R2: ninth bit used / ignored
    nine_bits = 1;
    host_write(8'h3C, 1'b1);
    wait_idle();
    chk(last_rx == 'h13C, "R2 ninth bit sent", last_rx, 'h13C);
    nine_bits = 0;
    host_write(8'h5A, 1'b1);
    wait_idle();
    chk(last_rx == 'h5A, "R2 ninth bit ignored", last_rx, 'h5A);

    // R4: refill before stop gives back-to-back frames
    host_write(8'h81, 1'b0);
    wait_frame_start();
    host_write(8'h7E, 1'b0);
    wait_idle();
    chk(last_rx == 'h7E, "R4 second frame", last_rx, 'h7E);
    chk(last_gap == 0, "R4 no idle gap", last_gap, 0);

    // R9: overwrite of a pending word
    cnt0 = rx_count;
    host_write(8'h11, 1'b0);
    wait_frame_start();
    host_write(8'h22, 1'b0);
    host_write(8'h33, 1'b0);
    wait_idle();
    chk(rx_count == cnt0 + 2, "R9 overwritten word dropped", rx_count, cnt0 + 2);
    chk(last_rx == 'h33, "R9 latest word sent", last_rx, 'h33);

    // R10: abort mid-frame, pending word survives
    host_write(8'hC3, 1'b0);
    wait_frame_start();
    host_write(8'h96, 1'b0);
    repeat (3 * tick_div) @(negedge clk);
    tx_en = 0;
    repeat (20) begin
      @(posedge clk); #2;
      chk(line_out == 1 && shift_empty == 1, "R10 line idle while disabled", line_out, 1);
    end
    chk(hold_empty == 0, "R10 buffer kept", hold_empty, 0);
    @(negedge clk);
    tx_en = 1;
    wait_idle();
    chk(last_rx == 'h96, "R10 pending word sent after enable", last_rx, 'h96);

    // Random blocks: config fixed per block, write timing swept
    for (int blk = 0; blk < 10; blk++) begin
      wait_idle();
      tick_div  = 1 + ($urandom % 6);
      nine_bits = $urandom % 2;
      irq_en    = $urandom % 2;
      for (int k = 0; k < 15; k++) begin
        int gap;
        gap = $urandom % 80;
        repeat (gap) @(negedge clk);
        host_write(8'($urandom), 1'($urandom));
      end
    end
    wait_idle();
    chk(exp_q.size() == 0, "R4 all frames delivered", exp_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule